// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a bus-mapped watchdog. An up-counter advances on a slow timebase tick (nominally 32 kHz), either on every tick or, with the prescaler enabled, once every 2^ratio ticks. Software keeps the system alive by writing the trigger register with a value different from the previous one, which reloads the counter from the load register. If software fails to do so and the running counter passes all-ones, the block reloads itself and raises a one-cycle reset request.

Bus writes to the control, load, trigger and start/stop registers are posted. Each write lands in a bus-side holding register and sets a pending bit. The value moves into the counter domain on the next slow tick, and the pending bit then clears. Stopping and starting need a two-word key sequence on the start/stop register, and the two words must arrive back to back. The bus side runs on the fast clock, and the slow tick arrives as a one-cycle enable in that clock.

Top module: `kwdt_top`

## Requirements
- R1: After reset the timer is running with counter 0, load 0, prescaler disabled, no pending bits and `rst_req` low. Each slow tick that carries no transfer then adds one to the counter.
- R2: A bus write to control (0x24), load (0x2C), trigger (0x30) or start/stop (0x48) sets its pending bit in the status register (0x34). The bits are: control bit 0, load bit 2, trigger bit 3, start/stop bit 4. The bit clears on the next tick, which also transfers the value.
- R3: Writing 0x0000AAAA and then 0x00005555 to start/stop stops the timer. A stopped counter does not change on later ticks, apart from trigger reloads.
- R4: Writing 0x0000BBBB and then 0x00004444 to start/stop starts the timer. The first word 0x0000BBBB is accepted from any sequence state.
- R5: A key sequence completes only when its two words are transferred consecutively. Any other value transferred between them cancels the sequence, and the run state stays unchanged.
- R6: A trigger transfer whose value differs from the previously transferred trigger value loads the counter from the load value (the new load value if it transfers in the same tick), with no count in that tick. A trigger value equal to the previous one has no effect.
- R7: Control bit 5 enables the prescaler and bits 4:2 hold the ratio v. When enabled, the running counter advances once every 2^v ticks; when disabled, on every tick. A tick that transfers control or reloads the counter clears the prescale phase and does not count.
- R8: When the running counter advances from 0xFFFFFFFF, it is loaded from the load value and `rst_req` is high for exactly one clock cycle.
- R9: Reads return: revision (0x00) = fixed 8-bit revision in bits 7:0, upper bits zero; control = held value masked to bits 5:2; load and trigger = held values; counter (0x28) = live count; unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Slow timebase strobe, one clock wide, never in two consecutive cycles |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rst_req | output | 1 | One-cycle reset request on counter overflow |

## Verification
The hardest case to reach is the wrap from all-ones, because from reset it takes 2^32 advances. The stimulus first stops the timer with its key pair. It then loads a value three counts below the wrap and forces a reload with a fresh trigger pattern. After a restart, the bench counts ticks to the wrap and counts the cycles in which `rst_req` is high. Each prescaler ratio, and the disabled case, is swept over the same stop, load, trigger and start sequence, and the expected count is computed from the tick total.

// File: rtl/kwdt_pkg.sv
// Package: register offsets, key words and posted-register indices shared
// by the keyed watchdog modules. Assumes an 8-bit byte offset space.
package kwdt_pkg;
    localparam logic [7:0] A_REV  = 8'h00;
    localparam logic [7:0] A_CTRL = 8'h24;
    localparam logic [7:0] A_CNT  = 8'h28;
    localparam logic [7:0] A_LOAD = 8'h2C;
    localparam logic [7:0] A_TRIG = 8'h30;
    localparam logic [7:0] A_PEND = 8'h34;
    localparam logic [7:0] A_KEY  = 8'h48;

    localparam int unsigned NPOST  = 4;
    localparam int unsigned P_CTRL = 0;
    localparam int unsigned P_LOAD = 1;
    localparam int unsigned P_TRIG = 2;
    localparam int unsigned P_KEY  = 3;

    localparam logic [31:0] KEY_STOP1  = 32'h0000_AAAA;
    localparam logic [31:0] KEY_STOP2  = 32'h0000_5555;
    localparam logic [31:0] KEY_START1 = 32'h0000_BBBB;
    localparam logic [31:0] KEY_START2 = 32'h0000_4444;

    typedef enum logic [1:0] {KS_IDLE, KS_STOP1, KS_START1} key_st_t;

    // Bus offset of each posted register.
    function automatic logic [7:0] post_addr(int unsigned i);
        case (i)
            P_CTRL:  return A_CTRL;
            P_LOAD:  return A_LOAD;
            P_TRIG:  return A_TRIG;
            default: return A_KEY;
        endcase
    endfunction

    // Bit position of each posted register in the pending status word.
    function automatic int unsigned stat_pos(int unsigned i);
        case (i)
            P_CTRL:  return 0;
            P_LOAD:  return 2;
            P_TRIG:  return 3;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/kwdt_bus.sv
// Bus front end: holds each posted register and its pending flag, and
// releases the value into the counter domain on the next slow tick. It
// decodes reads combinationally. A write in the same cycle as a tick keeps
// the register pending.
module kwdt_bus #(
    parameter int unsigned DW  = 32,
    parameter int unsigned PW  = 3,
    parameter logic [7:0]  REV = 8'h21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          we,
    input  logic [7:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] cnt,
    output logic [DW-1:0] rdata,
    output logic          ap_ctrl,
    output logic          ap_load,
    output logic          ap_trig,
    output logic          ap_key,
    output logic [DW-1:0] h_ctrl,
    output logic [DW-1:0] h_load,
    output logic [DW-1:0] h_trig,
    output logic [DW-1:0] h_key
);
    import kwdt_pkg::*;

    localparam logic [DW-1:0] CTRL_MASK = DW'(((1 << (PW + 1)) - 1) << 2);

    logic [DW-1:0] hold   [NPOST];
    logic          pend_q [NPOST];
    logic          hit    [NPOST];
    logic          apply  [NPOST];

    for (genvar i = 0; i < NPOST; i++) begin : g_post
        assign hit[i]   = we && (addr == post_addr(i));
        assign apply[i] = pend_q[i] && tick && !hit[i];

        // Capture a bus write and track whether it still awaits transfer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold[i]   <= '0;
                pend_q[i] <= 1'b0;
            end else if (hit[i]) begin
                hold[i]   <= wdata;
                pend_q[i] <= 1'b1;
            end else if (tick) begin
                pend_q[i] <= 1'b0;
            end
        end

        a_r2_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> pend_q[i]);
        a_r2_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && pend_q[i] && !hit[i]) |=> !pend_q[i]);
    end

    assign ap_ctrl = apply[P_CTRL];
    assign ap_load = apply[P_LOAD];
    assign ap_trig = apply[P_TRIG];
    assign ap_key  = apply[P_KEY];
    assign h_ctrl  = hold[P_CTRL];
    assign h_load  = hold[P_LOAD];
    assign h_trig  = hold[P_TRIG];
    assign h_key   = hold[P_KEY];

    // Read multiplexer over the register map.
    always_comb begin
        rdata = '0;
        case (addr)
            A_REV:  rdata = DW'(REV);
            A_CTRL: rdata = hold[P_CTRL] & CTRL_MASK;
            A_CNT:  rdata = cnt;
            A_LOAD: rdata = hold[P_LOAD];
            A_TRIG: rdata = hold[P_TRIG];
            A_KEY:  rdata = hold[P_KEY];
            A_PEND: for (int i = 0; i < NPOST; i++) rdata[stat_pos(i)] = pend_q[i];
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/kwdt_key.sv
// Key sequencer: tracks the two-word start and stop sequences over the
// transferred start/stop words and holds the run state. It assumes one
// transfer per slow tick. Any unrelated word returns it to idle.
module kwdt_key #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          apply,
    input  logic [DW-1:0] word,
    output logic          running
);
    import kwdt_pkg::*;

    key_st_t st_q;

    // Advance the sequence on each transferred word and update the run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= KS_IDLE;
            running <= 1'b1;
        end else if (apply) begin
            st_q <= KS_IDLE;
            if (word == DW'(KEY_STOP1))       st_q <= KS_STOP1;
            else if (word == DW'(KEY_START1)) st_q <= KS_START1;
            else if (word == DW'(KEY_STOP2) && st_q == KS_STOP1)   running <= 1'b0;
            else if (word == DW'(KEY_START2) && st_q == KS_START1) running <= 1'b1;
        end
    end

    a_r4_run_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(running));
    a_r5_no_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && st_q == KS_IDLE) |=> $stable(running));
    a_r3_stop_done: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && st_q == KS_STOP1 && word == DW'(KEY_STOP2)) |=> !running);
endmodule

// File: rtl/kwdt_count.sv
// Counter domain: holds the transferred control, load and trigger values,
// divides the slow tick with the prescaler, runs the up-counter and flags
// overflow. It assumes tick is never high in two consecutive cycles.
module kwdt_count #(
    parameter int unsigned DW = 32,
    parameter int unsigned PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          running,
    input  logic          ctrl_ap,
    input  logic [PW:0]   ctrl_val,
    input  logic          load_ap,
    input  logic [DW-1:0] load_val,
    input  logic          trig_ap,
    input  logic [DW-1:0] trig_val,
    output logic [DW-1:0] cnt,
    output logic          rst_req
);
    localparam int unsigned PCW = (1 << PW) - 1;

    logic          pre_en;
    logic [PW-1:0] ratio;
    logic [DW-1:0] load_q, trig_q, load_eff;
    logic [PCW-1:0] pcnt, mask;
    logic          reload, hold_pc, step;

    assign load_eff = load_ap ? load_val : load_q;
    assign reload   = trig_ap && (trig_val != trig_q);
    assign hold_pc  = reload || ctrl_ap;
    assign mask     = PCW'((1 << ratio) - 1);
    assign step     = tick && running && !hold_pc && (!pre_en || pcnt == mask);

    // Latch the configuration values transferred from the bus side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_en <= 1'b0;
            ratio  <= '0;
            load_q <= '0;
            trig_q <= '0;
        end else begin
            if (ctrl_ap) {pre_en, ratio} <= ctrl_val;
            if (load_ap) load_q <= load_val;
            if (trig_ap) trig_q <= trig_val;
        end
    end

    // Prescale phase: restart on reload or control change, else count ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pcnt <= '0;
        else if (hold_pc)            pcnt <= '0;
        else if (tick && running)    pcnt <= step ? '0 : pcnt + 1'b1;
    end

    // Main counter with trigger reload and overflow reload plus reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= step && (cnt == '1);
            if (reload)    cnt <= load_eff;
            else if (step) cnt <= (cnt == '1) ? load_eff : cnt + 1'b1;
        end
    end

    a_r7_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt != '1) |=> cnt == $past(cnt) + 1'b1);
    a_r8_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == '1) |=> (rst_req && cnt == $past(load_eff)));
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !reload) |=> $stable(cnt));
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> cnt == $past(load_eff));
endmodule

// File: rtl/kwdt_top.sv
// Keyed watchdog top: connects the bus front end, key sequencer and
// counter domain. The slow tick is a one-cycle enable in the bus clock.
module kwdt_top #(
    parameter int unsigned DW  = 32,
    parameter int unsigned PW  = 3,
    parameter logic [7:0]  REV = 8'h21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          bus_we,
    input  logic [7:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          rst_req
);
    logic          ap_ctrl, ap_load, ap_trig, ap_key, running;
    logic [DW-1:0] h_ctrl, h_load, h_trig, h_key, cnt;

    kwdt_bus #(.DW(DW), .PW(PW), .REV(REV)) u_bus (
        .clk(clk), .rst_n(rst_n), .tick(tick), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .cnt(cnt), .rdata(bus_rdata),
        .ap_ctrl(ap_ctrl), .ap_load(ap_load), .ap_trig(ap_trig), .ap_key(ap_key),
        .h_ctrl(h_ctrl), .h_load(h_load), .h_trig(h_trig), .h_key(h_key)
    );

    kwdt_key #(.DW(DW)) u_key (
        .clk(clk), .rst_n(rst_n), .apply(ap_key), .word(h_key), .running(running)
    );

    kwdt_count #(.DW(DW), .PW(PW)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .running(running),
        .ctrl_ap(ap_ctrl), .ctrl_val(h_ctrl[2 +: PW + 1]),
        .load_ap(ap_load), .load_val(h_load),
        .trig_ap(ap_trig), .trig_val(h_trig),
        .cnt(cnt), .rst_req(rst_req)
    );

    a_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: tb/kwdt_top_bench.sv
`timescale 1ns/1ps
module kwdt_top_bench;
    logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        rst_req;
    int          checks = 0, fails = 0, rst_cycles = 0;
    logic [31:0] pat = 32'h1234, v, base;

    kwdt_top u_kwdt_top (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req));

    always #2.5 clk = ~clk;
    always @(posedge clk) if (rst_n && rst_req) rst_cycles++;

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask
    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask
    task automatic tk();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask
    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tk();
    endtask
    task automatic wx(logic [7:0] a, logic [31:0] d);
        wr(a, d); tk();
    endtask
    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask
    task automatic stop_t();  wx(8'h48, 32'hAAAA); wx(8'h48, 32'h5555); endtask
    task automatic start_t(); wx(8'h48, 32'hBBBB); wx(8'h48, 32'h4444); endtask
    task automatic retrig();  pat = ~pat; wx(8'h30, pat); endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state and free running from reset
        rd(8'h28, v); chk("R1 counter", v, 0);
        rd(8'h34, v); chk("R1 pending", v, 0);
        rd(8'h2C, v); chk("R1 load", v, 0);
        chk("R1 rst_req", {31'b0, rst_req}, 0);
        rd(8'h00, v); chk("R9 revision", v, 32'h21);
        rd(8'h10, v); chk("R9 unmapped", v, 0);
        ticks(3);
        rd(8'h28, v); chk("R1 counts", v, 3);
        // R2 posted writes and pending bits
        wr(8'h24, 0); wr(8'h2C, 0); wr(8'h30, 0); wr(8'h48, 0);
        rd(8'h34, v); chk("R2 pending set", v, 32'h1D);
        tk();
        rd(8'h34, v); chk("R2 pending clear", v, 0);
        // R7 sweep every prescaler ratio plus disabled
        for (int cfg = 0; cfg < 9; cfg++) begin
            logic en;
            int   r, k;
            en = (cfg < 8);
            r  = (cfg < 8) ? cfg : 5;
            k  = 300;
            base = 32'h100 * cfg + 7;
            stop_t();
            wx(8'h24, {26'b0, en, r[2:0], 2'b00});
            wx(8'h2C, base);
            retrig();
            rd(8'h28, v); chk("R6 reload", v, base);
            ticks(5);
            rd(8'h28, v); chk("R3 frozen", v, base);
            start_t();
            ticks(k);
            rd(8'h28, v); chk("R7 prescale", v, base + (en ? (k >> r) : k));
        end
        // R6 same trigger value has no effect
        stop_t();
        wx(8'h24, 0);
        wx(8'h2C, 32'h500); retrig();
        wx(8'h2C, 32'h900); wx(8'h30, pat);
        rd(8'h28, v); chk("R6 same value ignored", v, 32'h500);
        retrig();
        rd(8'h28, v); chk("R6 new value reloads", v, 32'h900);
        // R5 broken start sequence, R4 start after restarted first word
        wx(8'h48, 32'hBBBB); wx(8'h48, 32'h1234); wx(8'h48, 32'h4444);
        ticks(4);
        rd(8'h28, v); chk("R5 start cancelled", v, 32'h900);
        wx(8'h48, 32'hAAAA); start_t();
        ticks(4);
        rd(8'h28, v); chk("R4 started", v, 32'h904);
        wx(8'h48, 32'hAAAA); wx(8'h48, 32'h0001); wx(8'h48, 32'h5555);
        ticks(2);
        rd(8'h28, v); chk("R5 stop cancelled", v, 32'h909);
        stop_t();
        ticks(3);
        rd(8'h28, v); chk("R3 stopped", v, 32'h90B);
        // R8 overflow
        wx(8'h2C, 32'hFFFF_FFFD); retrig(); start_t();
        rst_cycles = 0;
        ticks(2);
        rd(8'h28, v); chk("R8 at top", v, 32'hFFFF_FFFF);
        chk("R8 no early pulse", rst_cycles, 0);
        tk(); @(negedge clk);
        rd(8'h28, v); chk("R8 wrap reload", v, 32'hFFFF_FFFD);
        chk("R8 one-cycle pulse", rst_cycles, 1);
        ticks(5);
        chk("R8 second wrap", rst_cycles, 2);
        rd(8'h28, v); chk("R8 after second wrap", v, 32'hFFFF_FFFF);
        // R9 control read mask
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, v); chk("R9 control mask", v, 32'h3C);
        rd(8'h2C, v); chk("R9 load read", v, 32'hFFFF_FFFD);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule